// File: doc/BRIEF.md
# Hardware Lock Manager for Two Multithreaded Processors

This block arbitrates mutual-exclusion locks shared by the thread contexts of two processors, four contexts each, for eight requesters in total. When a thread executes an instruction flagged as a lock or unlock, its processor presents an acquire or release request carrying the thread slot and a lock number. A free lock is granted immediately. If another thread holds the lock, the unit records the requester as a waiter and tells its processor to park that context, so the thread never polls.

When the holder releases the lock, ownership passes directly to one recorded waiter, which may sit on either processor. That thread is woken with a resume pulse, and its pending acquire counts as already granted. Each requester has a global index equal to processor × 4 + thread slot. The lock table has one entry per lock number, holding a busy flag, the owner's index and an 8-bit waiter mask.

Top module: `lock_sync_unit`

## Requirements
- R1: An accepted acquire of a free lock sets bit `index` of `ack` for exactly one cycle, in the cycle after acceptance, and that thread becomes the owner.
- R2: An accepted acquire of a lock owned by a different thread sets bit `index` of `suspend` (not `ack`) for one cycle, in the cycle after acceptance, and records the thread as a waiter.
- R3: A release by the owner when there are no waiters sets the owner's `ack` bit in the next cycle and frees the lock, so a later acquire by any thread is granted.
- R4: A release by the owner when waiters exist gives the lock to the first waiter found by searching indices upward from the releaser's index + 1, wrapping from 7 to 0. In the same cycle as the releaser's `ack` bit, the `resume` bit for that waiter is set, and the waiter is removed from the mask.
- R5: A waiter on the other processor is resumed in the same way as a waiter on the same processor.
- R6: A release by a thread that does not own the lock (or of a free lock) changes no table state, gives no `ack`, `suspend` or `resume`, and pulses `release_err` for one cycle in the cycle after acceptance.
- R7: An acquire by the current owner of that lock is acknowledged with its `ack` bit and leaves ownership and waiters unchanged.
- R8: At most one request is accepted per cycle. When both processors present a request and processor 0 is accepted, processor 1 is accepted on the next cycle. `req_ready[p]` is high when processor p's presented request is taken this cycle, or when p presents nothing.
- R9: The 16 lock numbers are independent: holding one lock does not affect acquiring another.
- R10: After reset all locks are free, every response output is 0 and `req_ready` is 2'b11.
- R11: Every accepted request produces exactly one of `ack`, `suspend` or `release_err` in the next cycle. No response appears in a cycle that follows no acceptance, apart from the `resume` that accompanies a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Request present, one bit per processor |
| req_acq | input | 2 | 1 = acquire, 0 = release, per processor |
| req_tid | input | 4 | Thread slot, 2 bits per processor (processor p at bits 2p+1:2p) |
| req_lock | input | 8 | Lock number, 4 bits per processor (processor p at bits 4p+3:4p) |
| req_ready | output | 2 | Request taken this cycle, per processor |
| ack | output | 8 | Grant or release acknowledge, one bit per global index |
| suspend | output | 8 | Park this thread, one bit per global index |
| resume | output | 8 | Wake this thread, now the owner, one bit per global index |
| release_err | output | 1 | Release by a non-owner was ignored |

## Verification
Every response (`ack`, `suspend`, `resume`, `release_err`) is registered, so it appears exactly one cycle after the rising edge that accepts the request. A `resume` appears in the same cycle as the releaser's `ack`. `req_ready` is combinational, so each task presents a request at the falling edge, checks `req_ready` within that half cycle, and samples the responses 1 ns after the accepting rising edge, before removing the request. A dual-request task checks that processor 0 is taken first and that processor 1's response follows one cycle later.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic {
    OP_RELEASE = 1'b0,
    OP_ACQUIRE = 1'b1
  } lsu_op_e;
endpackage

// File: rtl/lsu_arbiter.sv
module lsu_arbiter #(
  parameter int N_PROC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PROC-1:0] valid_i,
  output logic [N_PROC-1:0] grant_o
);
  logic [N_PROC-1:0] lost_q;
  logic [N_PROC-1:0] cand;

  always_comb begin
    cand = (|(valid_i & lost_q)) ? (valid_i & lost_q) : valid_i;
    grant_o = '0;
    for (int p = N_PROC - 1; p >= 0; p--) begin
      if (cand[p]) grant_o = N_PROC'(1) << p;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lost_q <= '0;
    else     lost_q <= valid_i & ~grant_o;
  end
endmodule

// File: rtl/lsu_rr_pick.sv
module lsu_rr_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] start_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 1; k--) begin
      int j;
      j = int'(start_i) + k;
      if (j >= N) j = j - N;
      if (mask_i[j]) begin
        found_o = 1'b1;
        idx_o   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int N_REQ  = 8,
  parameter int N_LOCK = 16,
  parameter int GW     = $clog2(N_REQ),
  parameter int LW     = $clog2(N_LOCK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  lsu_op_e          in_op,
  input  logic [GW-1:0]    in_gid,
  input  logic [LW-1:0]    in_lock,
  output logic [N_REQ-1:0] ack_o,
  output logic [N_REQ-1:0] suspend_o,
  output logic [N_REQ-1:0] resume_o,
  output logic             err_o
);
  logic             held_q  [N_LOCK];
  logic [GW-1:0]    owner_q [N_LOCK];
  logic [N_REQ-1:0] waitm_q [N_LOCK];

  logic             cur_held, nx_held, wr_en, is_owner, nxt_found, err_d;
  logic [GW-1:0]    cur_owner, nx_owner, nxt_idx;
  logic [N_REQ-1:0] cur_wait, nx_wait, ack_d, sus_d, res_d;

  assign cur_held  = held_q[in_lock];
  assign cur_owner = owner_q[in_lock];
  assign cur_wait  = waitm_q[in_lock];
  assign is_owner  = cur_held && (cur_owner == in_gid);

  lsu_rr_pick #(.N(N_REQ), .IW(GW)) i_pick (
    .mask_i (cur_wait),
    .start_i(in_gid),
    .found_o(nxt_found),
    .idx_o  (nxt_idx)
  );

  always_comb begin
    nx_held  = cur_held;
    nx_owner = cur_owner;
    nx_wait  = cur_wait;
    wr_en    = 1'b0;
    ack_d    = '0;
    sus_d    = '0;
    res_d    = '0;
    err_d    = 1'b0;
    if (in_valid) begin
      if (in_op == OP_ACQUIRE) begin
        if (!cur_held) begin
          nx_held        = 1'b1;
          nx_owner       = in_gid;
          ack_d[in_gid]  = 1'b1;
          wr_en          = 1'b1;
        end else if (is_owner) begin
          ack_d[in_gid]  = 1'b1;
        end else begin
          nx_wait[in_gid] = 1'b1;
          sus_d[in_gid]   = 1'b1;
          wr_en           = 1'b1;
        end
      end else begin
        if (!is_owner) begin
          err_d = 1'b1;
        end else begin
          ack_d[in_gid] = 1'b1;
          wr_en         = 1'b1;
          if (nxt_found) begin
            nx_owner         = nxt_idx;
            nx_wait[nxt_idx] = 1'b0;
            res_d[nxt_idx]   = 1'b1;
          end else begin
            nx_held = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LOCK; i++) begin
        held_q[i]  <= 1'b0;
        owner_q[i] <= '0;
        waitm_q[i] <= '0;
      end
      ack_o     <= '0;
      suspend_o <= '0;
      resume_o  <= '0;
      err_o     <= 1'b0;
    end else begin
      ack_o     <= ack_d;
      suspend_o <= sus_d;
      resume_o  <= res_d;
      err_o     <= err_d;
      if (wr_en) begin
        held_q[in_lock]  <= nx_held;
        owner_q[in_lock] <= nx_owner;
        waitm_q[in_lock] <= nx_wait;
      end
    end
  end
endmodule

// File: rtl/lock_sync_unit.sv
module lock_sync_unit
  import lsu_pkg::*;
#(
  parameter int N_PROC = 2,
  parameter int N_THR  = 4,
  parameter int N_LOCK = 16,
  parameter int TW     = $clog2(N_THR),
  parameter int LW     = $clog2(N_LOCK)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PROC-1:0]         req_valid,
  input  logic [N_PROC-1:0]         req_acq,
  input  logic [N_PROC*TW-1:0]      req_tid,
  input  logic [N_PROC*LW-1:0]      req_lock,
  output logic [N_PROC-1:0]         req_ready,
  output logic [N_PROC*N_THR-1:0]   ack,
  output logic [N_PROC*N_THR-1:0]   suspend,
  output logic [N_PROC*N_THR-1:0]   resume,
  output logic                      release_err
);
  localparam int N_REQ = N_PROC * N_THR;
  localparam int GW    = $clog2(N_REQ);

  logic [N_PROC-1:0] grant;
  logic              sel_valid;
  lsu_op_e           sel_op;
  logic [GW-1:0]     sel_gid;
  logic [LW-1:0]     sel_lock;

  lsu_arbiter #(.N_PROC(N_PROC)) i_arb (
    .clk    (clk),
    .rst    (rst),
    .valid_i(req_valid),
    .grant_o(grant)
  );

  assign req_ready = grant | ~req_valid;

  always_comb begin
    sel_valid = 1'b0;
    sel_op    = OP_RELEASE;
    sel_gid   = '0;
    sel_lock  = '0;
    for (int p = 0; p < N_PROC; p++) begin
      if (grant[p]) begin
        sel_valid = 1'b1;
        sel_op    = lsu_op_e'(req_acq[p]);
        sel_gid   = GW'(p * N_THR) + GW'(req_tid[p*TW +: TW]);
        sel_lock  = req_lock[p*LW +: LW];
      end
    end
  end

  lsu_core #(.N_REQ(N_REQ), .N_LOCK(N_LOCK), .GW(GW), .LW(LW)) i_core (
    .clk      (clk),
    .rst      (rst),
    .in_valid (sel_valid),
    .in_op    (sel_op),
    .in_gid   (sel_gid),
    .in_lock  (sel_lock),
    .ack_o    (ack),
    .suspend_o(suspend),
    .resume_o (resume),
    .err_o    (release_err)
  );
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int N_PROC = 2,
  parameter int N_REQ  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_PROC-1:0] req_valid,
  input logic [N_PROC-1:0] req_ready,
  input logic [N_REQ-1:0]  ack,
  input logic [N_REQ-1:0]  suspend,
  input logic [N_REQ-1:0]  resume,
  input logic              release_err
);
  logic taken;
  assign taken = |(req_valid & req_ready);

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_valid & req_ready)); // R8

  AST_LOSER_NEXT: assert property (@(posedge clk) disable iff (rst)
    (req_valid[0] && req_valid[1] && req_ready[0]) |=> req_ready[1]); // R8

  AST_SINGLE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack | suspend)); // R2

  AST_RESUME_PAIRED: assert property (@(posedge clk) disable iff (rst)
    (|resume) |-> ($onehot(ack) && ((ack & resume) == '0) && $onehot(resume))); // R4

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    release_err |-> ((ack | suspend | resume) == '0)); // R6

  AST_RESPONSE_DUE: assert property (@(posedge clk) disable iff (rst)
    taken |=> ((|ack) || (|suspend) || release_err)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !taken |=> ((ack | suspend | resume) == '0 && !release_err)); // R11
endmodule

bind lock_sync_unit lsu_checker #(.N_PROC(N_PROC), .N_REQ(N_PROC*N_THR)) i_lsu_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .ack        (ack),
  .suspend    (suspend),
  .resume     (resume),
  .release_err(release_err)
);

// File: tb/test_lock_sync_unit.sv
module test_lock_sync_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] req_valid = '0;
  logic [1:0] req_acq = '0;
  logic [3:0] req_tid = '0;
  logic [7:0] req_lock = '0;
  logic [1:0] req_ready;
  logic [7:0] ack, suspend, resume;
  logic       release_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] a_s, s_s, r_s;
  logic       e_s;

  always #4 clk = ~clk;

  lock_sync_unit i_lock_sync_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_acq(req_acq),
    .req_tid(req_tid), .req_lock(req_lock), .req_ready(req_ready),
    .ack(ack), .suspend(suspend), .resume(resume), .release_err(release_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(int p, bit acq, int tid, int lk);
    req_valid[p]        = 1'b1;
    req_acq[p]          = acq;
    req_tid[p*2 +: 2]   = 2'(tid);
    req_lock[p*4 +: 4]  = 4'(lk);
  endtask

  task automatic capture();
    a_s = ack; s_s = suspend; r_s = resume; e_s = release_err;
  endtask

  // one request from one processor; responses sampled after the accepting edge
  task automatic single(int p, bit acq, int tid, int lk);
    @(negedge clk);
    put(p, acq, tid, lk);
    @(posedge clk);
    #1;
    capture();
    req_valid[p] = 1'b0;
  endtask

  task automatic expect_resp(string req, logic [7:0] a, logic [7:0] s,
                             logic [7:0] r, logic e);
    check({req, " ack"}, 32'(a_s), 32'(a));
    check({req, " suspend"}, 32'(s_s), 32'(s));
    check({req, " resume"}, 32'(r_s), 32'(r));
    check({req, " release_err"}, 32'(e_s), 32'(e));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 ready", 32'(req_ready), 32'h3);
    check("R10 outputs", {ack, suspend, resume, 7'b0, release_err}, 32'h0);
  endtask

  task automatic t_grant_and_block();
    single(0, 1, 0, 3);                      // index 0 takes lock 3
    expect_resp("R1", 8'h01, 8'h00, 8'h00, 1'b0);
    single(1, 1, 1, 3);                      // index 5 blocks
    expect_resp("R2", 8'h00, 8'h20, 8'h00, 1'b0);
    single(0, 1, 2, 3);                      // index 2 blocks
    expect_resp("R2 second", 8'h00, 8'h04, 8'h00, 1'b0);
  endtask

  task automatic t_bad_release();
    single(1, 0, 3, 3);                      // index 7 not owner
    expect_resp("R6 non-owner", 8'h00, 8'h00, 8'h00, 1'b1);
    single(1, 0, 3, 12);                     // free lock
    expect_resp("R6 free lock", 8'h00, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic t_reacquire();
    single(0, 1, 0, 3);
    expect_resp("R7", 8'h01, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_handover();
    single(0, 0, 0, 3);                      // waiters {2,5}: 2 is next after 0
    expect_resp("R4", 8'h01, 8'h00, 8'h04, 1'b0);
    single(0, 0, 2, 3);                      // waiter 5 on processor 1
    expect_resp("R5 cross", 8'h04, 8'h00, 8'h20, 1'b0);
    single(1, 0, 1, 3);                      // no waiters left
    expect_resp("R3 free", 8'h20, 8'h00, 8'h00, 1'b0);
    single(1, 1, 3, 3);                      // index 7 now gets it
    expect_resp("R3 regrant", 8'h80, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_wrap();
    single(1, 1, 2, 9);                      // index 6 owns lock 9
    expect_resp("R1 lock9", 8'h40, 8'h00, 8'h00, 1'b0);
    single(0, 1, 1, 9);                      // index 1 waits
    expect_resp("R2 lock9 a", 8'h00, 8'h02, 8'h00, 1'b0);
    single(1, 0, 3, 9);                      // index 7 not owner: waiters stay
    expect_resp("R6 lock9", 8'h00, 8'h00, 8'h00, 1'b1);
    single(1, 1, 3, 3);                      // index 7 re-acquires lock 3
    expect_resp("R7 lock3", 8'h80, 8'h00, 8'h00, 1'b0);
    single(0, 0, 1, 9);                      // waiter cannot release
    expect_resp("R6 waiter", 8'h00, 8'h00, 8'h00, 1'b1);
    single(1, 1, 1, 9);                      // index 5 waits too
    expect_resp("R2 lock9 b", 8'h00, 8'h20, 8'h00, 1'b0);
    single(1, 0, 2, 9);                      // from 6: 7 empty, wraps past 0 to 1
    expect_resp("R4 wrap", 8'h40, 8'h00, 8'h02, 1'b0);
    single(0, 0, 1, 9);                      // from 1: next is 5
    expect_resp("R4 after wrap", 8'h02, 8'h00, 8'h20, 1'b0);
  endtask

  task automatic t_dual();
    @(negedge clk);
    put(0, 1, 3, 0);                         // index 3, lock 0
    put(1, 1, 0, 15);                        // index 4, lock 15
    #1;
    check("R8 ready both", 32'(req_ready), 32'h1);
    @(posedge clk);
    #1;
    capture();
    req_valid[0] = 1'b0;
    expect_resp("R9 p0 first", 8'h08, 8'h00, 8'h00, 1'b0);
    #1;
    check("R8 p1 next", 32'(req_ready[1]), 32'h1);
    @(posedge clk);
    #1;
    capture();
    req_valid[1] = 1'b0;
    expect_resp("R9 p1 second", 8'h10, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_idle();
    @(posedge clk);
    #1;
    capture();
    expect_resp("R11 idle", 8'h00, 8'h00, 8'h00, 1'b0);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL R11 watchdog: actual hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_grant_and_block();
    t_bad_release();
    t_reacquire();
    t_handover();
    t_wrap();
    t_dual();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule